// File: doc/BRIEF.md
# Paged Direct Address Generator

This block turns a short offset taken from an instruction into a full memory address for direct addressing. Instead of adding a base and an offset across the whole address width, it forms a 16-bit in-page sum of a pointer and the offset and places that sum under a separate page field. It can also build an I/O address by placing the upper bits of an I/O page pointer above the low offset bits.

Four modes are offered: data page, user stack, system stack and I/O page. The two stack modes share one stack page register. The base registers are written through a simple write port. A request is sampled on a clock edge, and the result appears together with a valid strobe after that same edge. Each request is computed from the base register values as they stood before the edge that samples it.

Top module: `pdag_top`

## Requirements
- R1: After reset, `out_valid` and `out_is_io` are 0 and both address outputs are 0. Every base register reads as 0, so the first requests see zero pointers and zero pages.
- R2: With `mode`=0 (data page), the result is `out_daddr` = {data page register[6:0], (data pointer + offset) mod 2^16}. The offset is zero-extended.
- R3: With `mode`=1 (user stack), the result is `out_daddr` = {stack page register[6:0], (user stack pointer + offset) mod 2^16}.
- R4: With `mode`=2 (system stack), the result is `out_daddr` = {stack page register[6:0], (system stack pointer + offset) mod 2^16}. The same page register serves both stack modes.
- R5: With `mode`=3 (I/O page), the result is `out_ioaddr` = {I/O pointer[15:6], offset[5:0]} and `out_is_io`=1. Offset bit 6 has no effect in this mode.
- R6: A carry out of the 16-bit pointer-plus-offset sum is dropped. The page bits [22:16] always equal the page register.
- R7: A request sampled on edge k gives `out_valid`=1 after edge k. With no request, `out_valid`=0 and both addresses are 0.
- R8: `reg_we` writes `reg_wdata` on an edge to the register that `reg_sel` picks: 0 data pointer, 1 data page, 2 user stack pointer, 3 system stack pointer, 4 stack page, 5 I/O pointer. A page write keeps only bits [6:0]. Codes 6 and 7 change nothing. A request on the same edge as a write still sees the old value.
- R9: During a valid result, the address output that the mode does not use is 0: `out_ioaddr` for the data and stack modes, `out_daddr` for I/O mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Address request |
| mode | input | 2 | 0 data page, 1 user stack, 2 system stack, 3 I/O page |
| offset | input | 7 | Offset from the instruction |
| reg_we | input | 1 | Base register write enable |
| reg_sel | input | 3 | Base register select |
| reg_wdata | input | 16 | Base register write data |
| out_valid | output | 1 | Result valid |
| out_is_io | output | 1 | Result is an I/O address |
| out_daddr | output | 23 | Data-space address |
| out_ioaddr | output | 16 | I/O address |

## Verification
The assertions assume that `req`, `mode` and `reg_we` are driven to known values from the first edge after reset. The stability property also assumes that two back-to-back data-page requests with the same offset and no write between them must give the same address. The bench drives every input on the falling edge, so inputs are always settled when they are sampled. It keeps `req` low during reset and feeds writes, requests and offsets that all stay inside the declared port widths. Directed sequences place a write on the same edge as a request and write to the unused select codes. A random phase mixes all four modes with writes.

// File: rtl/pdag_pkg.sv
package pdag_pkg;
    localparam int PTR_W   = 16;
    localparam int DADDR_W = 23;
    localparam int PG_W    = DADDR_W - PTR_W;
    localparam int OFS_W   = 7;
    localparam int IO_W    = 16;
    localparam int IOOFS_W = 6;
    localparam int IOPG_W  = IO_W - IOOFS_W;
    localparam int SEL_W   = 3;

    typedef enum logic [1:0] {
        AM_DPAGE = 2'd0,
        AM_USTK  = 2'd1,
        AM_SSTK  = 2'd2,
        AM_IOPG  = 2'd3
    } amode_e;

    localparam logic [SEL_W-1:0] BR_DPTR  = 3'd0;
    localparam logic [SEL_W-1:0] BR_DEXT  = 3'd1;
    localparam logic [SEL_W-1:0] BR_USP   = 3'd2;
    localparam logic [SEL_W-1:0] BR_SSP   = 3'd3;
    localparam logic [SEL_W-1:0] BR_SEXT  = 3'd4;
    localparam logic [SEL_W-1:0] BR_IOPTR = 3'd5;

    typedef struct packed {
        logic [PTR_W-1:0] dptr;
        logic [PG_W-1:0]  dext;
        logic [PTR_W-1:0] usp;
        logic [PTR_W-1:0] ssp;
        logic [PG_W-1:0]  sext;
        logic [PTR_W-1:0] ioptr;
    } bregs_t;

    typedef struct packed {
        logic               vld;
        logic               is_io;
        logic [DADDR_W-1:0] daddr;
        logic [IO_W-1:0]    ioaddr;
    } aout_t;
endpackage

// File: rtl/pdag_bregs.sv
module pdag_bregs
    import pdag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [PTR_W-1:0] wdata,
    output bregs_t           regs
);
    bregs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (sel)
                BR_DPTR:  regs_d.dptr  = wdata;
                BR_DEXT:  regs_d.dext  = wdata[PG_W-1:0];
                BR_USP:   regs_d.usp   = wdata;
                BR_SSP:   regs_d.ssp   = wdata;
                BR_SEXT:  regs_d.sext  = wdata[PG_W-1:0];
                BR_IOPTR: regs_d.ioptr = wdata;
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/pdag_agen.sv
module pdag_agen
    import pdag_pkg::*;
(
    input  bregs_t           regs,
    input  amode_e           mode,
    input  logic [OFS_W-1:0] offset,
    output aout_t            res
);
    logic [PTR_W-1:0] base;
    logic [PG_W-1:0]  page;
    logic [PTR_W-1:0] in_page;

    always_comb begin
        case (mode)
            AM_DPAGE: begin base = regs.dptr; page = regs.dext; end
            AM_USTK:  begin base = regs.usp;  page = regs.sext; end
            AM_SSTK:  begin base = regs.ssp;  page = regs.sext; end
            default:  begin base = '0;        page = '0;        end
        endcase
        in_page = base + PTR_W'(offset);
    end

    always_comb begin
        res = '0;
        res.vld = 1'b1;
        if (mode == AM_IOPG) begin
            res.is_io  = 1'b1;
            res.ioaddr = {regs.ioptr[IO_W-1:IOOFS_W], offset[IOOFS_W-1:0]};
        end else begin
            res.daddr = {page, in_page};
        end
    end
endmodule

// File: rtl/pdag_top.sv
module pdag_top
    import pdag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [1:0]         mode,
    input  logic [OFS_W-1:0]   offset,
    input  logic               reg_we,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [PTR_W-1:0]   reg_wdata,
    output logic               out_valid,
    output logic               out_is_io,
    output logic [DADDR_W-1:0] out_daddr,
    output logic [IO_W-1:0]    out_ioaddr
);
    bregs_t regs;
    aout_t  calc;
    aout_t  out_d, out_q;

    pdag_bregs u_bregs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .regs  (regs)
    );

    pdag_agen u_agen (
        .regs   (regs),
        .mode   (amode_e'(mode)),
        .offset (offset),
        .res    (calc)
    );

    always_comb begin
        out_d = '0;
        if (req) out_d = calc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid  = out_q.vld;
    assign out_is_io  = out_q.is_io;
    assign out_daddr  = out_q.daddr;
    assign out_ioaddr = out_q.ioaddr;
endmodule

// File: rtl/pdag_chk.sv
module pdag_chk
    import pdag_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic [1:0]         mode,
    input logic [OFS_W-1:0]   offset,
    input logic               reg_we,
    input logic               out_valid,
    input logic               out_is_io,
    input logic [DADDR_W-1:0] out_daddr,
    input logic [IO_W-1:0]    out_ioaddr
);
    p_req_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> out_valid);

    p_noreq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!out_valid && out_daddr == '0 && out_ioaddr == '0));

    p_io_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_io) |-> out_daddr == '0);

    p_data_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_io) |-> out_ioaddr == '0);

    p_io_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd3) |=> (out_is_io && out_ioaddr[IOOFS_W-1:0] == $past(offset[IOOFS_W-1:0])));

    p_dpage_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'd0 && $past(req) && $past(mode) == 2'd0 && !$past(reg_we)
         && offset == $past(offset)) |=> $stable(out_daddr));
endmodule

bind pdag_top pdag_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .mode       (mode),
    .offset     (offset),
    .reg_we     (reg_we),
    .out_valid  (out_valid),
    .out_is_io  (out_is_io),
    .out_daddr  (out_daddr),
    .out_ioaddr (out_ioaddr)
);

// File: tb/tb_pdag_top.sv
`timescale 1ns/1ps
module tb_pdag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  mode = '0;
    logic [6:0]  offset = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        out_valid, out_is_io;
    logic [22:0] out_daddr;
    logic [15:0] out_ioaddr;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    int m_dp = 0, m_dph = 0, m_sp = 0, m_ssp = 0, m_sph = 0, m_pdp = 0;

    always #2 clk = ~clk;

    pdag_top dut (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .offset(offset),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .out_valid(out_valid), .out_is_io(out_is_io),
        .out_daddr(out_daddr), .out_ioaddr(out_ioaddr)
    );

    task automatic check(string tag, int ev, int eio, int ed, int ei);
        total++;
        if (out_valid !== ev[0] || out_is_io !== eio[0] ||
            out_daddr !== ed[22:0] || out_ioaddr !== ei[15:0]) begin
            bad++;
            $display("FAIL %s: got v=%0d io=%0d d=%h i=%h exp v=%0d io=%0d d=%h i=%h",
                     tag, out_valid, out_is_io, out_daddr, out_ioaddr, ev, eio, ed, ei);
        end
    endtask

    task automatic step(string tag, bit r, int md, int of, bit w, int sl, int wd);
        int ev, eio, ed, ei;
        @(negedge clk);
        req = r; mode = md[1:0]; offset = of[6:0];
        reg_we = w; reg_sel = sl[2:0]; reg_wdata = wd[15:0];
        @(posedge clk);
        ev = 0; eio = 0; ed = 0; ei = 0;
        if (r) begin
            ev = 1;
            case (md)
                0: ed = (m_dph << 16) | ((m_dp + of) & 32'hFFFF);
                1: ed = (m_sph << 16) | ((m_sp + of) & 32'hFFFF);
                2: ed = (m_sph << 16) | ((m_ssp + of) & 32'hFFFF);
                default: begin eio = 1; ei = (m_pdp & 32'hFFC0) | (of & 63); end
            endcase
        end
        if (w) begin
            case (sl)
                0: m_dp  = wd & 32'hFFFF;
                1: m_dph = wd & 127;
                2: m_sp  = wd & 32'hFFFF;
                3: m_ssp = wd & 32'hFFFF;
                4: m_sph = wd & 127;
                5: m_pdp = wd & 32'hFFFF;
                default: ;
            endcase
        end
        @(negedge clk);
        req = 1'b0; reg_we = 1'b0;
        check(tag, ev, eio, ed, ei);
    endtask

    task automatic wr(int sl, int wd);
        step("R8", 1'b0, 0, 0, 1'b1, sl, wd);
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !finished) begin
                finished = 1;
                bad++; total++;
                $display("FAIL watchdog: got cycles=%0d exp fewer", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        step("R1", 1'b1, 0, 5, 1'b0, 0, 0);
        step("R1", 1'b1, 3, 7'h45, 1'b0, 0, 0);
        step("R7", 1'b0, 0, 9, 1'b0, 0, 0);
        wr(0, 16'h1234); wr(1, 16'h0055);
        step("R2", 1'b1, 0, 7'h10, 1'b0, 0, 0);
        step("R2", 1'b1, 0, 7'h7F, 1'b0, 0, 0);
        wr(0, 16'hFFF0);
        step("R6", 1'b1, 0, 7'h7F, 1'b0, 0, 0);
        wr(2, 16'hFFFF); wr(3, 16'h8000); wr(4, 16'hFFFF);
        step("R3", 1'b1, 1, 7'h01, 1'b0, 0, 0);
        step("R4", 1'b1, 2, 7'h22, 1'b0, 0, 0);
        wr(4, 16'h0003);
        step("R4", 1'b1, 2, 7'h00, 1'b0, 0, 0);
        step("R3", 1'b1, 1, 7'h03, 1'b0, 0, 0);
        wr(5, 16'hABFF);
        step("R5", 1'b1, 3, 7'h7F, 1'b0, 0, 0);
        step("R5", 1'b1, 3, 7'h3F, 1'b0, 0, 0);
        step("R9", 1'b1, 3, 7'h00, 1'b0, 0, 0);
        step("R8", 1'b1, 0, 7'h02, 1'b1, 0, 16'h0100);
        step("R8", 1'b1, 0, 7'h02, 1'b0, 0, 0);
        step("R8", 1'b0, 0, 0, 1'b1, 6, 16'hFFFF);
        step("R8", 1'b0, 0, 0, 1'b1, 7, 16'hFFFF);
        step("R8", 1'b1, 0, 7'h00, 1'b0, 0, 0);
        step("R8", 1'b1, 1, 7'h00, 1'b0, 0, 0);
        step("R8", 1'b1, 2, 7'h00, 1'b0, 0, 0);
        step("R8", 1'b1, 3, 7'h00, 1'b0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            int md;
            md = int'($urandom_range(0, 3));
            step(md == 0 ? "R2" : md == 1 ? "R3" : md == 2 ? "R4" : "R5",
                 bit'($urandom_range(0, 1)), md, int'($urandom_range(0, 127)),
                 bit'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 65535)));
        end
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule